// File: doc/BRIEF.md
# Three-Wire Serial Control Register

This block takes configuration words from a slow three-wire port (serial clock, serial data, strobe) and turns them into parallel settings for a dual-loop frequency synthesizer. All three pins are asynchronous to the system clock. Each pin passes through a two-stage synchronizer and then a three-sample majority filter. The filter rejects short glitches before any edge is detected. Data bits enter a shift register least-significant bit first, one bit on each filtered rising edge of the serial clock.

Each word ends in a 3-bit group code. On a filtered rising edge of the strobe, the block decodes that code and loads one of five register groups:

- loop-1 main divider
- loop-2 main divider
- loop-1 reference divider
- loop-2 reference divider
- option word

Every payload field sits at a fixed distance back from the code. Words of different lengths therefore share one 24-bit register, and surplus leading bits simply fall out of it. The option group must be written first. A divider word that arrives before it is discarded, and a sticky error flag is set.

Top module: `scr_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every field output, `opt_done` and `seq_err` become 0.
- R2: A data bit is taken on each filtered rising edge of `ser_clk`, earliest bit first. The group code is the last three bits. Written as (third-last, second-last, last), the codes are: 000 loop-1 main, 010 loop-2 main, 001 loop-1 reference, 011 loop-2 reference, 100 option.
- R3: Loop-1 main word (24 bits, first sent to last): a 6-bit swallow value, then a 12-bit main count, then SB1, SB2 and SBX, then the code. Each value is sent LSB first.
- R4: Loop-2 main word (22 bits): a 4-bit swallow value, then an 11-bit main count, then the frequency-switch bit, then SB1, SB2 and SBX, then the code.
- R5: Each reference word (18 bits) is a 12-bit count, then SB1, SB2 and SBX, then the code.
- R6: The option word (11 bits) is an 8-bit value followed by the code. Loading it sets `opt_done`, which stays set until reset.
- R7: On a strobe rising edge, only the addressed group changes. `pwr_save` = {SBX, SB2, SB1} is updated by every accepted divider word. No output changes without a strobe rising edge.
- R8: A divider word loaded while `opt_done` is 0 changes no output and sets `seq_err`, which stays set until reset. The codes 101, 110 and 111 change no output.
- R9: A pulse on `ser_clk` or `ser_stb` that lasts one system clock cycle causes no shift and no load.
- R10: Bits sent ahead of a word's own bits have no effect on what that word loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_stb | input | 1 | Strobe, asynchronous |
| l1_swallow | output | 6 | Loop-1 swallow value |
| l1_main | output | 12 | Loop-1 main count |
| l2_swallow | output | 4 | Loop-2 swallow value |
| l2_main | output | 11 | Loop-2 main count |
| l2_fsw | output | 1 | Loop-2 frequency-switch bit |
| l1_ref | output | 12 | Loop-1 reference count |
| l2_ref | output | 12 | Loop-2 reference count |
| pwr_save | output | 3 | {SBX, SB2, SB1} from the last accepted divider word |
| opt_word | output | 8 | Option value |
| opt_done | output | 1 | Option group has been written since reset |
| seq_err | output | 1 | A divider word arrived before the option group |

## Verification
Several internal faults show up only in the loaded fields, and they appear a few system cycles after the filtered strobe edge:

- A shift register that has slipped by one bit, for example after an accepted glitch, moves the code window. The next load then lands in the wrong group or with shifted field values.
- A wrong field offset corrupts the values of one group only.
- A broken option-first gate shows up as a divider field that changes while `seq_err` rises.
- A filter that passes single-cycle pulses corrupts the next word.

The bench compares every output after every word, so any of these faults is seen on the first strobe that follows it.

// File: rtl/scr_pkg.sv
// Package: shared widths, field offsets, group codes and the settings record.
// Assumes the shift register shifts toward bit 0, so the most recent bit
// sits at SR_W-1 and every field offset is counted back from the tail.
package scr_pkg;
    localparam int A1_W   = 6;
    localparam int N1_W   = 12;
    localparam int A2_W   = 4;
    localparam int N2_W   = 11;
    localparam int R_W    = 12;
    localparam int OPT_W  = 8;
    localparam int PS_W   = 3;
    localparam int CODE_W = 3;

    localparam int SR_W   = A1_W + N1_W + PS_W + CODE_W;
    localparam int PS_LO  = SR_W - CODE_W - PS_W;
    localparam int N1_LO  = PS_LO - N1_W;
    localparam int A1_LO  = N1_LO - A1_W;
    localparam int FS_POS = PS_LO - 1;
    localparam int N2_LO  = FS_POS - N2_W;
    localparam int A2_LO  = N2_LO - A2_W;
    localparam int R_LO   = PS_LO - R_W;
    localparam int OPT_LO = SR_W - CODE_W - OPT_W;

    typedef enum logic [2:0] {
        GRP_L1_MAIN = 3'b000,
        GRP_L2_MAIN = 3'b010,
        GRP_L1_REF  = 3'b001,
        GRP_L2_REF  = 3'b011,
        GRP_OPT     = 3'b100
    } grp_e;

    typedef struct packed {
        logic [A1_W-1:0]  l1_a;
        logic [N1_W-1:0]  l1_n;
        logic [A2_W-1:0]  l2_a;
        logic [N2_W-1:0]  l2_n;
        logic             fsw;
        logic [R_W-1:0]   r1;
        logic [R_W-1:0]   r2;
        logic [PS_W-1:0]  ps;
        logic [OPT_W-1:0] opt;
    } cfg_t;
endpackage

// File: rtl/scr_in_cond.sv
// Input conditioner: synchronizes one asynchronous pin and filters it.
// The filtered level is the majority of the last FILT_LEN synchronized samples.
// Assumes SYNC_LEN >= 2 and an odd FILT_LEN >= 3.
module scr_in_cond #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl
);
    localparam int HALF  = FILT_LEN / 2;
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_LEN-1:0] sync_q;
    logic [FILT_LEN-1:0] win_q;
    logic [CNT_W-1:0]    ones;
    logic                lvl_q;

    // Count the high samples held in the filter window.
    always_comb begin
        ones = '0;
        for (int i = 0; i < FILT_LEN; i++) begin
            ones = ones + CNT_W'(win_q[i]);
        end
    end

    // Synchronizer chain, sample window and majority-voted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            win_q  <= '0;
            lvl_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], pin};
            win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
            lvl_q  <= (ones > CNT_W'(HALF));
        end
    end

    assign lvl = lvl_q;
endmodule

// File: rtl/scr_shift.sv
// Serial shift register: on each enable it takes one bit in at the top and
// moves the old contents toward bit 0.
// An LSB-first word therefore ends with its fields in natural bit order.
module scr_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sr_q;

    // Take one bit in per filtered serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {din, sr_q[W-1:1]};
        end
    end

    assign word = sr_q;
endmodule

// File: rtl/scr_decode.sv
// Field decoder: slices every candidate field out of the shift register at
// its fixed distance from the tail, and rebuilds the 3-bit group code.
// The code is ordered (third-last, second-last, last).
// Purely combinational.
module scr_decode
    import scr_pkg::*;
(
    input  logic [SR_W-1:0] word,
    output logic [2:0]      code,
    output cfg_t            cand
);
    // Extract the group code and all field candidates.
    always_comb begin
        code      = {word[SR_W-3], word[SR_W-2], word[SR_W-1]};
        cand.l1_a = word[A1_LO +: A1_W];
        cand.l1_n = word[N1_LO +: N1_W];
        cand.l2_a = word[A2_LO +: A2_W];
        cand.l2_n = word[N2_LO +: N2_W];
        cand.fsw  = word[FS_POS];
        cand.r1   = word[R_LO +: R_W];
        cand.r2   = word[R_LO +: R_W];
        cand.ps   = word[PS_LO +: PS_W];
        cand.opt  = word[OPT_LO +: OPT_W];
    end
endmodule

// File: rtl/scr_bank.sv
// Register bank: on a load pulse it writes only the group named by the code.
// Divider groups are gated until the option group has been written; a gated
// write sets the sticky sequence error flag. Unused codes load nothing.
module scr_bank
    import scr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] code,
    input  cfg_t       cand,
    output cfg_t       cfg,
    output logic       opt_done,
    output logic       seq_err
);
    cfg_t cfg_q;
    logic done_q;
    logic err_q;

    // Group-selective load with option-first gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (load) begin
            case (code)
                GRP_OPT: begin
                    cfg_q.opt <= cand.opt;
                    done_q    <= 1'b1;
                end
                GRP_L1_MAIN: begin
                    if (done_q) begin
                        cfg_q.l1_a <= cand.l1_a;
                        cfg_q.l1_n <= cand.l1_n;
                        cfg_q.ps   <= cand.ps;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                GRP_L2_MAIN: begin
                    if (done_q) begin
                        cfg_q.l2_a <= cand.l2_a;
                        cfg_q.l2_n <= cand.l2_n;
                        cfg_q.fsw  <= cand.fsw;
                        cfg_q.ps   <= cand.ps;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                GRP_L1_REF: begin
                    if (done_q) begin
                        cfg_q.r1 <= cand.r1;
                        cfg_q.ps <= cand.ps;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                GRP_L2_REF: begin
                    if (done_q) begin
                        cfg_q.r2 <= cand.r2;
                        cfg_q.ps <= cand.ps;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cfg      = cfg_q;
    assign opt_done = done_q;
    assign seq_err  = err_q;
endmodule

// File: rtl/scr_top.sv
// Three-wire serial control register top.
// Conditions the three pins, detects the rising edges of the serial clock
// and the strobe, shifts the data in, and loads one group per strobe edge.
// Assumes each serial level is held for at least SYNC_LEN+FILT_LEN system cycles.
module scr_top
    import scr_pkg::*;
#(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_stb,
    output logic [A1_W-1:0]   l1_swallow,
    output logic [N1_W-1:0]   l1_main,
    output logic [A2_W-1:0]   l2_swallow,
    output logic [N2_W-1:0]   l2_main,
    output logic              l2_fsw,
    output logic [R_W-1:0]    l1_ref,
    output logic [R_W-1:0]    l2_ref,
    output logic [PS_W-1:0]   pwr_save,
    output logic [OPT_W-1:0]  opt_word,
    output logic              opt_done,
    output logic              seq_err
);
    localparam int N_PINS = 3;

    logic [N_PINS-1:0] pin_v;
    logic [N_PINS-1:0] lvl_v;
    logic [1:0]        prev_q;
    logic              clk_rise;
    logic              stb_rise;
    logic [SR_W-1:0]   word;
    logic [2:0]        code;
    cfg_t              cand;
    cfg_t              cfg;

    assign pin_v = {ser_stb, ser_dat, ser_clk};

    for (genvar g = 0; g < N_PINS; g++) begin : g_cond
        scr_in_cond #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_v[g]),
            .lvl   (lvl_v[g])
        );
    end

    // Remember the previous filtered levels of the serial clock and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 2'b00;
        end else begin
            prev_q <= {lvl_v[2], lvl_v[0]};
        end
    end

    assign clk_rise = lvl_v[0] & ~prev_q[0];
    assign stb_rise = lvl_v[2] & ~prev_q[1];

    scr_shift #(.W(SR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (clk_rise),
        .din      (lvl_v[1]),
        .word     (word)
    );

    scr_decode u_dec (
        .word (word),
        .code (code),
        .cand (cand)
    );

    scr_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (stb_rise),
        .code     (code),
        .cand     (cand),
        .cfg      (cfg),
        .opt_done (opt_done),
        .seq_err  (seq_err)
    );

    assign l1_swallow = cfg.l1_a;
    assign l1_main    = cfg.l1_n;
    assign l2_swallow = cfg.l2_a;
    assign l2_main    = cfg.l2_n;
    assign l2_fsw     = cfg.fsw;
    assign l1_ref     = cfg.r1;
    assign l2_ref     = cfg.r2;
    assign pwr_save   = cfg.ps;
    assign opt_word   = cfg.opt;
endmodule

// File: rtl/scr_chk.sv
// Checker for scr_top, attached with bind.
// Relates the outputs to the internal strobe edge and to the sticky flags.
module scr_chk
    import scr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             stb_rise,
    input logic [A1_W-1:0]  l1_swallow,
    input logic [N1_W-1:0]  l1_main,
    input logic [A2_W-1:0]  l2_swallow,
    input logic [N2_W-1:0]  l2_main,
    input logic             l2_fsw,
    input logic [R_W-1:0]   l1_ref,
    input logic [R_W-1:0]   l2_ref,
    input logic [PS_W-1:0]  pwr_save,
    input logic [OPT_W-1:0] opt_word,
    input logic             opt_done,
    input logic             seq_err
);
    // Outputs change only after a strobe edge (R7)
    p_hold_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_rise |=> $stable({l1_swallow, l1_main, l2_swallow, l2_main, l2_fsw,
                               l1_ref, l2_ref, pwr_save, opt_word, opt_done}));

    // At most one group changes per load (R7)
    p_one_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ {l1_swallow, l1_main} != $past({l1_swallow, l1_main}),
                     {l2_swallow, l2_main, l2_fsw} != $past({l2_swallow, l2_main, l2_fsw}),
                     l1_ref != $past(l1_ref),
                     l2_ref != $past(l2_ref),
                     opt_word != $past(opt_word) }) <= 1);

    // Divider fields are frozen until the option group is written (R8)
    p_gate_before_opt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_done |=> $stable({l1_swallow, l1_main, l2_swallow, l2_main, l2_fsw,
                               l1_ref, l2_ref, pwr_save}));

    // The sequence error flag is sticky (R8)
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    // The option-written flag is sticky (R6)
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        opt_done |=> opt_done);

    // The option-written flag rises only from a strobe edge (R6)
    p_done_from_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(opt_done) |-> $past(stb_rise));
endmodule

bind scr_top scr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_rise   (stb_rise),
    .l1_swallow (l1_swallow),
    .l1_main    (l1_main),
    .l2_swallow (l2_swallow),
    .l2_main    (l2_main),
    .l2_fsw     (l2_fsw),
    .l1_ref     (l1_ref),
    .l2_ref     (l2_ref),
    .pwr_save   (pwr_save),
    .opt_word   (opt_word),
    .opt_done   (opt_done),
    .seq_err    (seq_err)
);

// File: tb/tb_scr_top.sv
`timescale 1ns/1ps
// Bench for scr_top: directed corner cases plus seeded random words.
// A bench-side model of the register groups supplies the expected values.
module tb_scr_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_stb = 1'b0;

    logic [5:0]  l1_swallow;
    logic [11:0] l1_main;
    logic [3:0]  l2_swallow;
    logic [10:0] l2_main;
    logic        l2_fsw;
    logic [11:0] l1_ref;
    logic [11:0] l2_ref;
    logic [2:0]  pwr_save;
    logic [7:0]  opt_word;
    logic        opt_done;
    logic        seq_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Expected state
    logic [5:0]  e_l1a;
    logic [11:0] e_l1n;
    logic [3:0]  e_l2a;
    logic [10:0] e_l2n;
    logic        e_fs;
    logic [11:0] e_r1;
    logic [11:0] e_r2;
    logic [2:0]  e_ps;
    logic [7:0]  e_opt;
    logic        e_done;
    logic        e_err;

    always #2 clk = ~clk;

    scr_top dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
        .l1_swallow(l1_swallow), .l1_main(l1_main), .l2_swallow(l2_swallow),
        .l2_main(l2_main), .l2_fsw(l2_fsw), .l1_ref(l1_ref), .l2_ref(l2_ref),
        .pwr_save(pwr_save), .opt_word(opt_word), .opt_done(opt_done), .seq_err(seq_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "l1_swallow", 32'(l1_swallow), 32'(e_l1a));
        chk(req, "l1_main",    32'(l1_main),    32'(e_l1n));
        chk(req, "l2_swallow", 32'(l2_swallow), 32'(e_l2a));
        chk(req, "l2_main",    32'(l2_main),    32'(e_l2n));
        chk(req, "l2_fsw",     32'(l2_fsw),     32'(e_fs));
        chk(req, "l1_ref",     32'(l1_ref),     32'(e_r1));
        chk(req, "l2_ref",     32'(l2_ref),     32'(e_r2));
        chk(req, "pwr_save",   32'(pwr_save),   32'(e_ps));
        chk(req, "opt_word",   32'(opt_word),   32'(e_opt));
        chk(req, "opt_done",   32'(opt_done),   32'(e_done));
        chk(req, "seq_err",    32'(seq_err),    32'(e_err));
    endtask

    // Append a code (third-last, second-last, last) after a payload of plen bits.
    function automatic logic [31:0] frame(input logic [31:0] payload, input int plen,
                                          input logic [2:0] code);
        logic [31:0] w;
        w = payload;
        w[plen]     = code[2];
        w[plen + 1] = code[1];
        w[plen + 2] = code[0];
        return w;
    endfunction

    // Bench model of one load.
    task automatic model(input logic [31:0] p, input logic [2:0] code);
        case (code)
            3'b100: begin e_opt = p[7:0]; e_done = 1'b1; end
            3'b000: if (e_done) begin e_l1a = p[5:0]; e_l1n = p[17:6]; e_ps = p[20:18]; end
                    else e_err = 1'b1;
            3'b010: if (e_done) begin e_l2a = p[3:0]; e_l2n = p[14:4]; e_fs = p[15];
                        e_ps = p[18:16]; end
                    else e_err = 1'b1;
            3'b001: if (e_done) begin e_r1 = p[11:0]; e_ps = p[14:12]; end
                    else e_err = 1'b1;
            3'b011: if (e_done) begin e_r2 = p[11:0]; e_ps = p[14:12]; end
                    else e_err = 1'b1;
            default: ;
        endcase
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        wait_cyc(6);
        ser_clk = 1'b1;
        wait_cyc(6);
        ser_clk = 1'b0;
        wait_cyc(6);
    endtask

    task automatic strobe();
        wait_cyc(6);
        ser_stb = 1'b1;
        wait_cyc(6);
        ser_stb = 1'b0;
        wait_cyc(12);
    endtask

    // Send pre random lead bits, then len bits of w (bit 0 first), then strobe.
    task automatic send_word(input logic [31:0] w, input int len, input int pre);
        for (int i = 0; i < pre; i++) send_bit(1'($urandom));
        for (int i = 0; i < len; i++) send_bit(w[i]);
        strobe();
    endtask

    // Payload lengths per code.
    function automatic int plen_of(input logic [2:0] code);
        case (code)
            3'b000: return 21;
            3'b010: return 19;
            3'b001, 3'b011: return 15;
            default: return 8;
        endcase
    endfunction

    task automatic do_word(input logic [31:0] p, input logic [2:0] code, input int pre,
                           input string req);
        int pl;
        logic [31:0] pm;
        pl = plen_of(code);
        pm = p & ((32'd1 << pl) - 1);
        send_word(frame(pm, pl, code), pl + 3, pre);
        model(pm, code);
        check_all(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1357_2468);
        e_l1a = '0; e_l1n = '0; e_l2a = '0; e_l2n = '0; e_fs = 1'b0;
        e_r1 = '0; e_r2 = '0; e_ps = '0; e_opt = '0; e_done = 1'b0; e_err = 1'b0;
        wait_cyc(5);
        check_all("R1");
        rst_n = 1'b1;
        wait_cyc(5);

        // R8: divider before option is dropped and flags an error
        do_word(32'h001F_FFFF, 3'b000, 0, "R8");
        chk("R8", "seq_err set", 32'(seq_err), 32'd1);

        // R6: option load
        do_word(32'h0000_00A5, 3'b100, 0, "R6");

        // R3: loop-1 main, extreme values
        do_word({11'd0, 3'b101, 12'hFFF, 6'h3F}, 3'b000, 0, "R3");
        do_word({11'd0, 3'b010, 12'h801, 6'h01}, 3'b000, 0, "R3");
        // R4: loop-2 main
        do_word({13'd0, 3'b011, 1'b1, 11'h7FF, 4'h9}, 3'b010, 0, "R4");
        do_word({13'd0, 3'b100, 1'b0, 11'h401, 4'hF}, 3'b010, 0, "R4");
        // R5: reference words
        do_word({17'd0, 3'b110, 12'hABC}, 3'b001, 0, "R5");
        do_word({17'd0, 3'b001, 12'h123}, 3'b011, 0, "R5");

        // R8: unused codes change nothing
        do_word(32'h0000_00FF, 3'b101, 0, "R8");
        do_word(32'h0000_0033, 3'b110, 0, "R8");
        do_word(32'h0000_00CC, 3'b111, 0, "R8");

        // R10: lead bits ahead of shorter words
        do_word({17'd0, 3'b111, 12'h5A5}, 3'b001, 7, "R10");
        do_word(32'h0000_003C, 3'b100, 13, "R10");

        // R9: single-cycle glitch on the serial clock mid-word
        begin
            logic [31:0] w;
            w = frame({17'd0, 3'b010, 12'h6C3}, 15, 3'b011);
            for (int i = 0; i < 18; i++) begin
                send_bit(w[i]);
                if (i == 8) begin
                    ser_clk = 1'b1;
                    @(negedge clk);
                    ser_clk = 1'b0;
                    wait_cyc(6);
                end
            end
            // R9: single-cycle strobe glitch must not load
            ser_stb = 1'b1;
            @(negedge clk);
            ser_stb = 1'b0;
            wait_cyc(12);
            check_all("R9");
            strobe();
            model({17'd0, 3'b010, 12'h6C3}, 3'b011);
            check_all("R9");
        end

        // R7 and R2: seeded random mix of groups and lead bits
        for (int k = 0; k < 60; k++) begin
            int sel;
            logic [2:0] code;
            sel = $urandom_range(0, 7);
            case (sel)
                0: code = 3'b000;
                1: code = 3'b010;
                2: code = 3'b001;
                3: code = 3'b011;
                4: code = 3'b100;
                5: code = 3'b101;
                6: code = 3'b110;
                default: code = 3'b111;
            endcase
            do_word($urandom, code, $urandom_range(0, 3), (k % 2 == 0) ? "R7" : "R2");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule